// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block brings an asynchronous DRAM array out of power-up and then keeps it refreshed. After reset it waits out a long settling pause, then asks an access controller for the memory strobes and issues a run of refresh cycles in column-strobe-first order. Only after that run does it raise a ready flag. From then on it marks one refresh slot per refresh interval. Each slot raises a request, which stays up until the access controller grants the bus. The DRAM steps its own internal row counter, so the block drives no address.

When the access controller holds the bus for longer than one interval, the missed slots pile up in a small saturating backlog. All of them are issued back to back in the next grant. While it owns the bus, the block drives every column strobe, every row strobe and write enable. All row-strobe lines move together, so both half-word banks are refreshed in the same cycle. It hands the bus back with a one-clock done pulse. Every delay is given in nanoseconds and rounded up to whole clocks.

Top module: `dram_refresh_seq`

## Requirements
- R1: Out of reset, all strobes and we_n are high, and refresh_req, bus_own, refresh_done and mem_ready are low. The first refresh_req rises no earlier than T_PAUSE_NS (200 us) after reset release, and at most 4 clocks later than that.
- R2: The first grant carries exactly INIT_REFRESHES (8) refresh cycles. mem_ready rises one clock after the done pulse of that grant and never falls again before reset.
- R3: In every refresh cycle, all column strobes are low at least T_CSR_NS (10 ns) before the row strobes fall. They stay low at least T_CHR_NS (10 ns) after the row strobes fall.
- R4: While bus_own is high, we_n is high, which covers the whole span around each row-strobe fall.
- R5: Within a grant, the row strobes stay low for at least 50 ns and stay high for at least 30 ns between cycles. Consecutive row-strobe falls are at least 84 ns apart, and a row-strobe rise comes at least 5 ns before the next column-strobe fall.
- R6: All ras_n bits always carry the same value, and all cas_n bits always carry the same value.
- R7: After mem_ready, a refresh slot falls due every N_REFI = ceil(15600 ns / clock) clocks. With the grant given at once, successive refresh_req rises are exactly N_REFI clocks apart.
- R8: refresh_req stays high until refresh_gnt is seen. Before that, bus_own stays low and no strobe moves.
- R9: Slots missed while the grant is withheld are all issued in the next grant. The backlog saturates at 2^BACKLOG_W-1 (15) cycles.
- R10: Each grant ends with refresh_done high for exactly one clock, with bus_own and refresh_req low in that clock.
- R11: While bus_own is low, every ras_n and cas_n bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| refresh_gnt | input | 1 | Access controller hands the strobes to this block; held until refresh_done |
| refresh_req | output | 1 | Request for the strobes; high from slot due until release |
| bus_own | output | 1 | This block drives the strobes; steers the external strobe mux |
| refresh_done | output | 1 | One-clock release pulse after the last cycle of a grant |
| mem_ready | output | 1 | High once power-up initialization has finished |
| ras_n | output | NUM_RAS | Row strobes, active low, moved together |
| cas_n | output | NUM_CAS | Column strobes, active low, moved together |
| we_n | output | 1 | Write enable, held high (inactive) |

## Verification
The reset synchronizer adds two clocks, so the first request is due 2 to 4 clocks after the pause count, and the bench accepts only that window. mem_ready is compared one clock after the done pulse. A granted request moves the column strobes on the next edge, and a refresh cycle spans 6 clocks with the default parameters. The bench does not predict absolute edges for these. Its monitor samples on the falling clock edge and measures each strobe run in whole clocks against the nanosecond limits. The grant count comes from a queue: the driver pushes the expected number of cycles for each grant, and the monitor pops and compares that number at the done pulse. Grants in the backlog tests are given half an interval away from any slot, so the expected count does not depend on which edge a slot lands on.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRECH,
    ST_DONE
  } rfsh_state_e;

  // Round a nanosecond delay up to whole clocks, never less than one.
  function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned clk_ps);
    longint unsigned q;
    q = (longint'(ns) * 1000 + longint'(clk_ps) - 1) / longint'(clk_ps);
    if (q < 1) q = 1;
    return int'(q);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_rst_sync.sv
module rfsh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int unsigned PAUSE_CYC = 10000,
  parameter int unsigned SLOT_CYC  = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic pause_end,
  output logic slot_tick
);
  localparam int unsigned SPAN = (PAUSE_CYC > SLOT_CYC) ? PAUSE_CYC : SLOT_CYC;
  localparam int unsigned CW   = $clog2(SPAN + 1);
  localparam logic [CW-1:0] PAUSE_LAST = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] SLOT_LAST  = CW'(SLOT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          paused_q, paused_d;
  logic          cnt_en;

  always_comb begin
    cnt_d     = cnt_q;
    paused_d  = paused_q;
    cnt_en    = 1'b0;
    pause_end = 1'b0;
    slot_tick = 1'b0;
    if (!paused_q) begin
      cnt_en = 1'b1;
      if (cnt_q == PAUSE_LAST) begin
        cnt_d     = '0;
        paused_d  = 1'b1;
        pause_end = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (run_en) begin
      cnt_en = 1'b1;
      if (cnt_q == SLOT_LAST) begin
        cnt_d     = '0;
        slot_tick = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      paused_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q    <= cnt_d;
      paused_q <= paused_d;
    end
  end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned INIT_LOAD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  input  logic take,
  output logic pending
);
  localparam logic [WIDTH-1:0] FULL   = '1;
  localparam logic [WIDTH-1:0] LOAD_V = WIDTH'(INIT_LOAD);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = LOAD_V;
      cnt_en = 1'b1;
    end else if (tick && !take) begin
      if (cnt_q != FULL) begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end else if (take && !tick) begin
      if (cnt_q != '0) begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pending = (cnt_q != '0);
endmodule

// File: rtl/rfsh_strobe_fsm.sv
module rfsh_strobe_fsm
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned N_CSR   = 1,
  parameter int unsigned N_HOLD  = 3,
  parameter int unsigned N_PRE   = 2,
  parameter int unsigned NUM_RAS = 2,
  parameter int unsigned NUM_CAS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pending,
  input  logic               gnt,
  output logic               take,
  output logic               req,
  output logic               own,
  output logic               done,
  output logic [NUM_RAS-1:0] ras_n,
  output logic [NUM_CAS-1:0] cas_n,
  output logic               we_n
);
  localparam int unsigned DMAX = max_u(max_u(N_CSR, N_HOLD), N_PRE);
  localparam int unsigned DW   = $clog2(DMAX + 1);
  localparam logic [DW-1:0] CSR_LAST  = DW'(N_CSR - 1);
  localparam logic [DW-1:0] HOLD_LAST = DW'(N_HOLD - 1);
  localparam logic [DW-1:0] PRE_LAST  = DW'(N_PRE - 1);

  rfsh_state_e   state_q, state_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          dly_en;

  logic own_d, req_d, done_d, cas_lo_d, ras_lo_d;
  logic own_q, req_q, done_q, cas_lo_q, ras_lo_q;

  // next state
  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    dly_en  = 1'b0;
    take    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (pending) state_d = ST_REQ;
      ST_REQ: begin
        if (gnt) begin
          state_d = ST_SETUP;
          dly_d   = CSR_LAST;
          dly_en  = 1'b1;
        end
      end
      ST_SETUP: begin
        dly_en = 1'b1;
        if (dly_q == '0) begin
          state_d = ST_ACTIVE;
          dly_d   = HOLD_LAST;
          take    = 1'b1;
        end else begin
          dly_d = dly_q - 1'b1;
        end
      end
      ST_ACTIVE: begin
        dly_en = 1'b1;
        if (dly_q == '0) begin
          state_d = ST_PRECH;
          dly_d   = PRE_LAST;
        end else begin
          dly_d = dly_q - 1'b1;
        end
      end
      ST_PRECH: begin
        dly_en = 1'b1;
        if (dly_q == '0) begin
          if (pending) begin
            state_d = ST_SETUP;
            dly_d   = CSR_LAST;
          end else begin
            state_d = ST_DONE;
          end
        end else begin
          dly_d = dly_q - 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // outputs decoded from the next state, then registered
  always_comb begin
    own_d    = (state_d == ST_SETUP) || (state_d == ST_ACTIVE) || (state_d == ST_PRECH);
    req_d    = (state_d == ST_REQ) || own_d;
    done_d   = (state_d == ST_DONE);
    cas_lo_d = (state_d == ST_SETUP) || (state_d == ST_ACTIVE);
    ras_lo_d = (state_d == ST_ACTIVE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      own_q    <= 1'b0;
      req_q    <= 1'b0;
      done_q   <= 1'b0;
      cas_lo_q <= 1'b0;
      ras_lo_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      own_q    <= own_d;
      req_q    <= req_d;
      done_q   <= done_d;
      cas_lo_q <= cas_lo_d;
      ras_lo_q <= ras_lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
    end else if (dly_en) begin
      dly_q <= dly_d;
    end
  end

  // strobe fan-out: every line of a kind follows one register
  for (genvar gr = 0; gr < NUM_RAS; gr++) begin : g_ras
    assign ras_n[gr] = ~ras_lo_q;
  end
  for (genvar gc = 0; gc < NUM_CAS; gc++) begin : g_cas
    assign cas_n[gc] = ~cas_lo_q;
  end

  assign we_n = 1'b1;
  assign own  = own_q;
  assign req  = req_q;
  assign done = done_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS  = 20000,
  parameter int unsigned T_PAUSE_NS     = 200000,
  parameter int unsigned INIT_REFRESHES = 8,
  parameter int unsigned T_REFI_NS      = 15600,
  parameter int unsigned T_CSR_NS       = 10,
  parameter int unsigned T_CHR_NS       = 10,
  parameter int unsigned T_RAS_NS       = 50,
  parameter int unsigned T_RP_NS        = 30,
  parameter int unsigned T_RC_NS        = 84,
  parameter int unsigned T_RPC_NS       = 5,
  parameter int unsigned BACKLOG_W      = 4,
  parameter int unsigned NUM_RAS        = 2,
  parameter int unsigned NUM_CAS        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               refresh_gnt,
  output logic               refresh_req,
  output logic               bus_own,
  output logic               refresh_done,
  output logic               mem_ready,
  output logic [NUM_RAS-1:0] ras_n,
  output logic [NUM_CAS-1:0] cas_n,
  output logic               we_n
);
  localparam int unsigned N_PAUSE = ns_to_clk(T_PAUSE_NS, CLK_PERIOD_PS);
  localparam int unsigned N_REFI  = ns_to_clk(T_REFI_NS, CLK_PERIOD_PS);
  localparam int unsigned N_CSR   = ns_to_clk(T_CSR_NS, CLK_PERIOD_PS);
  localparam int unsigned N_HOLD  = max_u(ns_to_clk(T_RAS_NS, CLK_PERIOD_PS),
                                          ns_to_clk(T_CHR_NS, CLK_PERIOD_PS));
  localparam int unsigned N_RC    = ns_to_clk(T_RC_NS, CLK_PERIOD_PS);
  localparam int unsigned N_RC_LEFT = (N_RC > N_HOLD + N_CSR) ? (N_RC - N_HOLD - N_CSR) : 1;
  localparam int unsigned N_PRE   = max_u(max_u(ns_to_clk(T_RP_NS, CLK_PERIOD_PS),
                                                ns_to_clk(T_RPC_NS, CLK_PERIOD_PS)), N_RC_LEFT);

  logic rst_sync_n;
  logic pause_end, slot_tick, take, pending;
  logic ready_q;

  rfsh_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rfsh_timer #(
    .PAUSE_CYC (N_PAUSE),
    .SLOT_CYC  (N_REFI)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_en    (ready_q),
    .pause_end (pause_end),
    .slot_tick (slot_tick)
  );

  rfsh_backlog #(
    .WIDTH     (BACKLOG_W),
    .INIT_LOAD (INIT_REFRESHES)
  ) u_backlog (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (pause_end),
    .tick    (slot_tick),
    .take    (take),
    .pending (pending)
  );

  rfsh_strobe_fsm #(
    .N_CSR   (N_CSR),
    .N_HOLD  (N_HOLD),
    .N_PRE   (N_PRE),
    .NUM_RAS (NUM_RAS),
    .NUM_CAS (NUM_CAS)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pending (pending),
    .gnt     (refresh_gnt),
    .take    (take),
    .req     (refresh_req),
    .own     (bus_own),
    .done    (refresh_done),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n)
  );

  // ready latches on the first release
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ready_q <= 1'b0;
    end else if (refresh_done && !ready_q) begin
      ready_q <= 1'b1;
    end
  end

  assign mem_ready = ready_q;
endmodule

// File: rtl/rfsh_seq_checker.sv
module rfsh_seq_checker #(
  parameter int unsigned NUM_RAS = 2,
  parameter int unsigned NUM_CAS = 4,
  parameter int unsigned RAS_MIN = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               refresh_gnt,
  input logic               refresh_req,
  input logic               bus_own,
  input logic               refresh_done,
  input logic               mem_ready,
  input logic [NUM_RAS-1:0] ras_n,
  input logic [NUM_CAS-1:0] cas_n
);
  logic [7:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
    end else if (!ras_n[0]) begin
      if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
    end else begin
      lo_cnt <= '0;
    end
  end

  assert_cbr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> (cas_n == '0) && ($past(cas_n) == '0));

  assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> (32'(lo_cnt) >= RAS_MIN));

  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n == '1) && (cas_n == '1));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_gnt && !bus_own) |=> refresh_req);

  assert_own_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(refresh_gnt));

  assert_ready_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> $past(refresh_done));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_done |=> !refresh_done);

  assert_done_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_done |-> !bus_own && !refresh_req);
endmodule

bind dram_refresh_seq rfsh_seq_checker #(
  .NUM_RAS (NUM_RAS),
  .NUM_CAS (NUM_CAS),
  .RAS_MIN (N_HOLD)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .refresh_gnt  (refresh_gnt),
  .refresh_req  (refresh_req),
  .bus_own      (bus_own),
  .refresh_done (refresh_done),
  .mem_ready    (mem_ready),
  .ras_n        (ras_n),
  .cas_n        (cas_n)
);

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
  localparam int CLK_NS  = 20;
  localparam int NR      = 2;
  localparam int NC      = 4;
  localparam int WD_CYC  = 120000;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  localparam int N_PAUSE = cdiv(200000, CLK_NS);
  localparam int N_REFI  = cdiv(15600, CLK_NS);
  localparam int SAT_MAX = 15;

  logic          clk, rst_n, refresh_gnt;
  logic          refresh_req, bus_own, refresh_done, mem_ready, we_n;
  logic [NR-1:0] ras_n;
  logic [NC-1:0] cas_n;

  dram_refresh_seq u_dram_refresh_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .refresh_gnt  (refresh_gnt),
    .refresh_req  (refresh_req),
    .bus_own      (bus_own),
    .refresh_done (refresh_done),
    .mem_ready    (mem_ready),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n)
  );

  typedef struct { int count; string tag; } exp_t;
  exp_t exp_q[$];

  int  n_chk, n_bad, cyc;
  int  req_rises;
  int  req_rise_at[64];
  bit  auto_grant, ready_seen, finished;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_burst(input int n, input string tag);
    exp_t e;
    e.count = n;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      if (!rst_n) cyc = 0; else cyc = cyc + 1;
    end
  end

  // grant driver
  initial begin
    refresh_gnt = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n || refresh_done) refresh_gnt = 1'b0;
      else if (auto_grant && refresh_req) refresh_gnt = 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit prev_ras_hi, prev_ras_lo, prev_cas_hi, prev_done, prev_ready, prev_req;
    int cas_lo_run, ras_lo_run, ras_hi_run, cas_hold, last_fall, burst_cnt;
    bit have_fall;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_ras_hi = 1; prev_ras_lo = 0; prev_cas_hi = 1;
        prev_done = 0; prev_ready = 0; prev_req = 0;
        cas_lo_run = 0; ras_lo_run = 0; ras_hi_run = 0; cas_hold = 0;
        last_fall = 0; burst_cnt = 0; have_fall = 0;
      end else begin
        bit ras_lo, ras_hi, cas_lo, cas_hi;
        ras_lo = (ras_n == '0); ras_hi = (ras_n == '1);
        cas_lo = (cas_n == '0); cas_hi = (cas_n == '1);
        check((ras_lo || ras_hi) && (cas_lo || cas_hi), "R6", "strobe lines split",
              int'({ras_n, cas_n}), 0);
        if (!bus_own)
          check(ras_hi && cas_hi, "R11", "strobes idle high", int'({ras_n, cas_n}), 63);
        else
          check(we_n == 1'b1, "R4", "we_n while owned", int'(we_n), 1);

        if (prev_ras_hi && ras_lo) begin
          check(cas_lo_run * CLK_NS >= 10, "R3", "cas setup ns", cas_lo_run * CLK_NS, 10);
          if (have_fall) begin
            check((cyc - last_fall) * CLK_NS >= 84, "R5", "cycle ns",
                  (cyc - last_fall) * CLK_NS, 84);
            check(ras_hi_run * CLK_NS >= 30, "R5", "precharge ns", ras_hi_run * CLK_NS, 30);
          end
          burst_cnt++;
          last_fall = cyc;
          have_fall = 1;
        end
        if (prev_ras_lo && ras_hi) begin
          check(ras_lo_run * CLK_NS >= 50, "R5", "ras low ns", ras_lo_run * CLK_NS, 50);
          check(cas_hold * CLK_NS >= 10, "R3", "cas hold ns", cas_hold * CLK_NS, 10);
        end
        if (prev_cas_hi && cas_lo && have_fall)
          check(ras_hi_run * CLK_NS >= 5, "R5", "ras rise to cas fall ns",
                ras_hi_run * CLK_NS, 5);

        if (prev_ras_hi && ras_lo) cas_hold = cas_lo ? 1 : 0;
        else if (ras_lo && cas_lo) cas_hold++;
        else if (!ras_lo) cas_hold = 0;
        cas_lo_run = cas_lo ? cas_lo_run + 1 : 0;
        ras_lo_run = ras_lo ? ras_lo_run + 1 : 0;
        ras_hi_run = ras_hi ? ras_hi_run + 1 : 0;

        if (refresh_done) begin
          check(!bus_own && !refresh_req, "R10", "own/req at done",
                int'({bus_own, refresh_req}), 0);
          check(!prev_done, "R10", "done width", 2, 1);
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(burst_cnt == e.count, e.tag, "cycles in grant", burst_cnt, e.count);
          end
          burst_cnt = 0;
          have_fall = 0;
        end

        if (!prev_ready && mem_ready) begin
          check(prev_done, "R2", "ready one clock after done", int'(prev_done), 1);
          ready_seen = 1;
        end
        if (prev_ready && !mem_ready) check(1'b0, "R2", "ready fell", 0, 1);

        if (!prev_req && refresh_req) begin
          if (req_rises < 64) req_rise_at[req_rises] = cyc;
          req_rises++;
        end

        prev_ras_hi = ras_hi; prev_ras_lo = ras_lo; prev_cas_hi = cas_hi;
        prev_done = refresh_done; prev_ready = mem_ready; prev_req = refresh_req;
      end
    end
  end

  // watchdog
  initial begin
    for (int i = 0; i < WD_CYC; i++) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYC, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    n_chk = 0; n_bad = 0; req_rises = 0;
    auto_grant = 1; ready_seen = 0; finished = 0;
    rst_n = 1'b0;
    step(4);
    // R1 reset state
    check(refresh_req == 0 && bus_own == 0 && refresh_done == 0 && mem_ready == 0,
          "R1", "control outputs in reset",
          int'({refresh_req, bus_own, refresh_done, mem_ready}), 0);
    check(ras_n == '1 && cas_n == '1 && we_n == 1'b1, "R1", "strobes in reset",
          int'({ras_n, cas_n, we_n}), 127);
    rst_n = 1'b1;

    // R2 initialization burst
    expect_burst(8, "R2");
    while (req_rises < 1) step(1);
    check(req_rise_at[0] >= N_PAUSE && req_rise_at[0] <= N_PAUSE + 4, "R1",
          "first request cycle", req_rise_at[0], N_PAUSE);
    while (!ready_seen || exp_q.size() != 0) step(1);
    step(2);
    check(mem_ready == 1'b1, "R2", "ready after init", int'(mem_ready), 1);

    // R7 periodic slots with immediate grant
    for (int k = 0; k < 3; k++) expect_burst(1, "R7");
    while (req_rises < 4 || exp_q.size() != 0) step(1);
    check(req_rise_at[2] - req_rise_at[1] == N_REFI, "R7", "slot spacing a",
          req_rise_at[2] - req_rise_at[1], N_REFI);
    check(req_rise_at[3] - req_rise_at[2] == N_REFI, "R7", "slot spacing b",
          req_rise_at[3] - req_rise_at[2], N_REFI);

    // R8/R9 withheld grant, three slots collected
    auto_grant = 0;
    r = req_rises;
    while (req_rises == r) step(1);
    step(2 * N_REFI + N_REFI / 2);
    check(refresh_req == 1'b1, "R8", "request held", int'(refresh_req), 1);
    check(bus_own == 1'b0 && ras_n == '1 && cas_n == '1, "R8", "no strobe before grant",
          int'({bus_own, ras_n, cas_n}), 63);
    expect_burst(3, "R9");
    auto_grant = 1;
    while (exp_q.size() != 0) step(1);

    // R9 saturation of the backlog
    auto_grant = 0;
    r = req_rises;
    while (req_rises == r) step(1);
    step(19 * N_REFI + N_REFI / 2);
    expect_burst(SAT_MAX, "R9");
    auto_grant = 1;
    while (exp_q.size() != 0) step(1);

    // back to a single slot per grant
    expect_burst(1, "R7");
    while (exp_q.size() != 0) step(1);
    step(4);
    check(mem_ready == 1'b1 && bus_own == 1'b0, "R2", "ready held, bus released",
          int'({mem_ready, bus_own}), 2);

    finished = 1;
    summary();
    $finish;
  end
endmodule